// File: doc/BRIEF.md
# Two-Bank Flash Operation Controller

This block arbitrates access to a word-wide non-volatile array that is split into two halves by the top address bit. It takes one request per cycle: a read, a word program, a block erase, a suspend or resume of a running erase, or a flag clear. A timing engine holds the busy state for a fixed number of cycles per operation and applies the result to the array model when the count expires. While one half is being changed, reads to the other half are served from the array. A read aimed at the half that is busy returns the status byte instead.

The array holds 2^ADDR_W words of DATA_W bits. The upper BLK_W address bits select the block and the top address bit selects the bank. With the defaults there are 256 words in 16 blocks of 16 words, and bank 1 covers 0x80 to 0xFF. Status bits: 0 busy, 1 done, 2 program error, 3 erase suspended, 4 refused program, 5 conflict, 6 bank of the running operation (1 only while busy), 7 zero. A read through `req_op` returns the status byte in the low bits of `rd_data`, with the upper bits zero.

Top module: `dbf_ctrl`

## Requirements
- R1: After reset every word reads 16'hFFFF and the status byte is 0.
- R2: A program (req_op 1) stores old AND data into the addressed word once the operation finishes. A later read (req_op 0) returns that value.
- R3: If program data has a 1 where the stored word has a 0, status bit 2 is set.
- R4: Busy (status bit 0) stays high for exactly PROG_CYC cycles for a program and ERS_CYC cycles of running time for an erase. Time spent suspended does not count. Done (bit 1) is set at completion and cleared when a new program or erase starts.
- R5: Every read gives rd_valid one cycle later. A read to the bank that is not busy returns array data.
- R6: A read to the bank of the running operation returns the status byte.
- R7: A program or erase request while an operation runs is rejected, sets status bit 5, and leaves the array unchanged. An erase request while an erase is suspended is also rejected.
- R8: A suspend (req_op 3) during an erase stops it. Busy drops and bit 3 is set. The suspended block still reads its old data. A resume (req_op 4) runs the remaining cycles, and then every word of the block reads all ones.
- R9: While an erase is suspended, a program to another block runs normally. A program to the suspended block is refused, sets bit 4, and leaves the word unchanged.
- R10: An erase (req_op 2) changes only the block selected by the upper BLK_W address bits.
- R11: A clear (req_op 5) resets status bits 1, 2, 4 and 5.
- R12: Codes 6 and 7 on req_op have no effect on status or array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | ADDR_W | Word address |
| req_data | input | DATA_W | Program data |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | DATA_W | Array word or status byte |
| status | output | 8 | Status byte |

## Verification
A wrong bank decision shows on the next read result. Status appears where array data was expected, or the reverse, one cycle after the read request. A wrong busy counter shows at the completion edge, so the busy-length count against PROG_CYC and ERS_CYC catches it as soon as the operation should end. A wrongly saved suspend count is caught by counting only the busy cycles that follow a resume. A lost AND, a missed erase word or an erase that strays into a neighbouring block stays hidden until that word is read, so each operation is followed by reads of the target word, both ends of the erased block and a word in the neighbouring block.

// File: rtl/dbf_pkg.sv
package dbf_pkg;
  typedef enum logic [2:0] {
    OP_READ   = 3'd0,
    OP_PROG   = 3'd1,
    OP_ERASE  = 3'd2,
    OP_SUSP   = 3'd3,
    OP_RESUME = 3'd4,
    OP_CLEAR  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_PROG  = 2'd1,
    ACT_ERASE = 2'd2
  } act_e;

  localparam int ST_W      = 8;
  localparam int ST_BUSY   = 0;
  localparam int ST_DONE   = 1;
  localparam int ST_PERR   = 2;
  localparam int ST_SUSP   = 3;
  localparam int ST_SERR   = 4;
  localparam int ST_CERR   = 5;
  localparam int ST_BANK   = 6;
endpackage

// File: rtl/dbf_arbiter.sv
module dbf_arbiter
  import dbf_pkg::*;
#(
  parameter int BLK_W = 4
) (
  input  logic             req_valid,
  input  logic [2:0]       req_op,
  input  logic [BLK_W-1:0] req_blk,
  input  act_e             act,
  input  logic             cnt_last,
  input  logic             susp,
  input  logic [BLK_W-1:0] susp_blk,
  output logic             rd_en,
  output logic             start_prog,
  output logic             start_erase,
  output logic             do_susp,
  output logic             do_resume,
  output logic             do_clear,
  output logic             conflict_set,
  output logic             refuse_set
);
  logic idle;
  logic hit_susp;
  logic is_prog;
  logic is_erase;

  always_comb begin
    idle     = (act == ACT_NONE);
    hit_susp = susp && (req_blk == susp_blk);
    is_prog  = req_valid && (req_op == OP_PROG);
    is_erase = req_valid && (req_op == OP_ERASE);

    rd_en        = req_valid && (req_op == OP_READ);
    start_prog   = is_prog && idle && !hit_susp;
    refuse_set   = is_prog && idle && hit_susp;
    start_erase  = is_erase && idle && !susp;
    conflict_set = (is_prog && !idle) || (is_erase && (!idle || susp));
    do_susp      = req_valid && (req_op == OP_SUSP) && (act == ACT_ERASE) && !cnt_last;
    do_resume    = req_valid && (req_op == OP_RESUME) && idle && susp;
    do_clear     = req_valid && (req_op == OP_CLEAR);
  end

  // R7
  always_comb begin
    one_action_chk: assert ($onehot0({start_prog, start_erase, refuse_set, do_resume}))
      else $error("more than one start decision in a cycle");
  end
endmodule

// File: rtl/dbf_engine.sv
module dbf_engine
  import dbf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_W    = 4,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 4,
  parameter int ERS_CYC  = 12,
  parameter int CNT_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_prog,
  input  logic              start_erase,
  input  logic              do_susp,
  input  logic              do_resume,
  input  logic              do_clear,
  input  logic              conflict_set,
  input  logic              refuse_set,
  input  logic              prog_bad,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output act_e              act,
  output logic              cnt_last,
  output logic              susp,
  output logic [BLK_W-1:0]  susp_blk,
  output logic              fin_prog,
  output logic              fin_erase,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic [ST_W-1:0]   status
);
  localparam int OFF_W = ADDR_W - BLK_W;

  act_e              act_q, act_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;
  logic              susp_q, susp_n;
  logic [BLK_W-1:0]  sblk_q, sblk_n;
  logic [CNT_W-1:0]  scnt_q, scnt_n;
  logic              done_q, done_n;
  logic              perr_q, perr_n;
  logic              serr_q, serr_n;
  logic              cerr_q, cerr_n;
  logic              run_en;

  always_comb begin
    cnt_last  = (cnt_q == CNT_W'(1));
    fin_prog  = (act_q == ACT_PROG) && cnt_last;
    fin_erase = (act_q == ACT_ERASE) && cnt_last;
    run_en    = (act_q != ACT_NONE) || start_prog || start_erase || do_resume;

    act_n  = act_q;
    cnt_n  = cnt_q;
    addr_n = addr_q;
    data_n = data_q;
    susp_n = susp_q;
    sblk_n = sblk_q;
    scnt_n = scnt_q;
    done_n = done_q;
    perr_n = perr_q;
    serr_n = serr_q;
    cerr_n = cerr_q;

    if (act_q != ACT_NONE) begin
      if (cnt_last) act_n = ACT_NONE;
      else          cnt_n = cnt_q - CNT_W'(1);
    end
    if (do_clear) begin
      done_n = 1'b0;
      perr_n = 1'b0;
      serr_n = 1'b0;
      cerr_n = 1'b0;
    end
    if (fin_prog || fin_erase) done_n = 1'b1;
    if (start_prog) begin
      act_n  = ACT_PROG;
      cnt_n  = CNT_W'(PROG_CYC);
      addr_n = req_addr;
      data_n = req_data;
      done_n = 1'b0;
      if (prog_bad) perr_n = 1'b1;
    end
    if (start_erase) begin
      act_n  = ACT_ERASE;
      cnt_n  = CNT_W'(ERS_CYC);
      addr_n = req_addr;
      done_n = 1'b0;
    end
    if (do_susp) begin
      act_n  = ACT_NONE;
      susp_n = 1'b1;
      sblk_n = addr_q[ADDR_W-1 -: BLK_W];
      scnt_n = cnt_q - CNT_W'(1);
    end
    if (do_resume) begin
      act_n  = ACT_ERASE;
      cnt_n  = scnt_q;
      addr_n = {sblk_q, {OFF_W{1'b0}}};
      susp_n = 1'b0;
    end
    if (conflict_set) cerr_n = 1'b1;
    if (refuse_set)   serr_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= ACT_NONE;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (run_en) begin
      act_q  <= act_n;
      cnt_q  <= cnt_n;
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      susp_q <= 1'b0;
      sblk_q <= '0;
      scnt_q <= '0;
      done_q <= 1'b0;
      perr_q <= 1'b0;
      serr_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      susp_q <= susp_n;
      sblk_q <= sblk_n;
      scnt_q <= scnt_n;
      done_q <= done_n;
      perr_q <= perr_n;
      serr_q <= serr_n;
      cerr_q <= cerr_n;
    end
  end

  always_comb begin
    act      = act_q;
    susp     = susp_q;
    susp_blk = sblk_q;
    op_addr  = addr_q;
    op_data  = data_q;
    status   = '0;
    status[ST_BUSY] = (act_q != ACT_NONE);
    status[ST_DONE] = done_q;
    status[ST_PERR] = perr_q;
    status[ST_SUSP] = susp_q;
    status[ST_SERR] = serr_q;
    status[ST_CERR] = cerr_q;
    status[ST_BANK] = (act_q != ACT_NONE) && addr_q[ADDR_W-1];
  end

  // R4
  busy_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q != ACT_NONE) |-> (cnt_q != '0))
    else $error("active operation with empty counter");

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_prog || fin_erase) |=> (done_q && act_q == ACT_NONE))
    else $error("completion did not raise done");

  // R7
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q == ACT_PROG && !cnt_last) |=> (act_q == ACT_PROG && addr_q == $past(addr_q)))
    else $error("running program replaced");

  // R8
  susp_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(susp_q) |-> (act_q == ACT_NONE && scnt_q != '0))
    else $error("suspend left engine running or saved no cycles");
endmodule

// File: rtl/dbf_array.sv
module dbf_array
  import dbf_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              rd_status_sel,
  input  logic [ST_W-1:0]   status_in,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              wr_prog,
  input  logic              wr_erase,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_data,
  output logic [DATA_W-1:0] cur_word,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFF_W = ADDR_W - BLK_W;
  localparam int WPB   = 1 << OFF_W;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] op_word;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;

  always_comb begin
    cur_word = mem_q[rd_addr];
    op_word  = mem_q[op_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
    end else begin
      if (wr_prog) mem_q[op_addr] <= op_word & op_data;
      if (wr_erase) begin
        for (int i = 0; i < WPB; i++)
          mem_q[{op_addr[ADDR_W-1 -: BLK_W], OFF_W'(i)}] <= '1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else begin
      rd_valid_q <= rd_en;
      if (rd_en)
        rd_data_q <= rd_status_sel ? {{(DATA_W-ST_W){1'b0}}, status_in} : cur_word;
    end
  end

  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

  // R2
  prog_clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_prog |=> ((mem_q[$past(op_addr)] & ~$past(op_word)) == '0))
    else $error("program set a bit");

  // R10
  erase_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_erase |=> (mem_q[{$past(op_addr[ADDR_W-1 -: BLK_W]), OFF_W'(WPB-1)}] == '1))
    else $error("erased block not all ones");

  // R5
  rd_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid_q)
    else $error("read result missing");
endmodule

// File: rtl/dbf_ctrl.sv
module dbf_ctrl
  import dbf_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_W    = 4,
  parameter int DATA_W   = 16,
  parameter int PROG_CYC = 4,
  parameter int ERS_CYC  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [7:0]        status
);
  localparam int MAX_CYC = (PROG_CYC > ERS_CYC) ? PROG_CYC : ERS_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]        rst_sync_q;
  logic              rst_n_s;
  act_e              act;
  logic              cnt_last;
  logic              susp;
  logic [BLK_W-1:0]  susp_blk;
  logic              rd_en, start_prog, start_erase, do_susp, do_resume, do_clear;
  logic              conflict_set, refuse_set;
  logic              fin_prog, fin_erase;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_data;
  logic [ST_W-1:0]   st;
  logic [DATA_W-1:0] cur_word;
  logic              prog_bad;
  logic              status_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  dbf_arbiter #(.BLK_W(BLK_W)) u_arb (
    .req_valid    (req_valid),
    .req_op       (req_op),
    .req_blk      (req_addr[ADDR_W-1 -: BLK_W]),
    .act          (act),
    .cnt_last     (cnt_last),
    .susp         (susp),
    .susp_blk     (susp_blk),
    .rd_en        (rd_en),
    .start_prog   (start_prog),
    .start_erase  (start_erase),
    .do_susp      (do_susp),
    .do_resume    (do_resume),
    .do_clear     (do_clear),
    .conflict_set (conflict_set),
    .refuse_set   (refuse_set)
  );

  always_comb begin
    prog_bad   = |(~cur_word & req_data);
    status_sel = (act != ACT_NONE) && (req_addr[ADDR_W-1] == op_addr[ADDR_W-1]);
  end

  dbf_engine #(
    .ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W),
    .PROG_CYC(PROG_CYC), .ERS_CYC(ERS_CYC), .CNT_W(CNT_W)
  ) u_eng (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_prog   (start_prog),
    .start_erase  (start_erase),
    .do_susp      (do_susp),
    .do_resume    (do_resume),
    .do_clear     (do_clear),
    .conflict_set (conflict_set),
    .refuse_set   (refuse_set),
    .prog_bad     (prog_bad),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .act          (act),
    .cnt_last     (cnt_last),
    .susp         (susp),
    .susp_blk     (susp_blk),
    .fin_prog     (fin_prog),
    .fin_erase    (fin_erase),
    .op_addr      (op_addr),
    .op_data      (op_data),
    .status       (st)
  );

  dbf_array #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .DATA_W(DATA_W)) u_arr (
    .clk           (clk),
    .rst_n         (rst_n_s),
    .rd_en         (rd_en),
    .rd_status_sel (status_sel),
    .status_in     (st),
    .rd_addr       (req_addr),
    .wr_prog       (fin_prog),
    .wr_erase      (fin_erase),
    .op_addr       (op_addr),
    .op_data       (op_data),
    .cur_word      (cur_word),
    .rd_valid      (rd_valid),
    .rd_data       (rd_data)
  );

  assign status = st;

  // R6
  busy_bank_read_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (rd_en && status_sel) |=> (rd_data == {{(DATA_W-ST_W){1'b0}}, $past(st)}))
    else $error("busy bank read did not return status");

  // R9
  susp_blk_safe_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (act == ACT_PROG && susp) |-> (op_addr[ADDR_W-1 -: BLK_W] != susp_blk))
    else $error("program running on suspended block");
endmodule

// File: tb/dbf_ctrl_tb.sv
`timescale 1ns/1ps
module dbf_ctrl_tb;
  localparam int PROG_CYC = 4;
  localparam int ERS_CYC  = 12;

  logic        clk;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_op;
  logic [7:0]  req_addr;
  logic [15:0] req_data;
  logic        rd_valid;
  logic [15:0] rd_data;
  logic [7:0]  status;

  int errs;
  int checks;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  dbf_ctrl #(.PROG_CYC(PROG_CYC), .ERS_CYC(ERS_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .status(status)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // monitor: pops expected read results
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) check("R5 unexpected read result", {16'h0, rd_data}, 32'hDEAD);
      else begin
        string t;
        logic [15:0] e;
        t = tag_q.pop_front();
        e = exp_q.pop_front();
        check(t, {16'h0, rd_data}, {16'h0, e});
      end
    end
  end

  task automatic issue(input logic [2:0] op, input logic [7:0] a, input logic [15:0] d);
    req_valid = 1'b1;
    req_op    = op;
    req_addr  = a;
    req_data  = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issue(3'd0, a, 16'h0);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (status[0]) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_idle();
    while (status[0]) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog: run did not end");
    finish_run();
  end

  initial begin
    int n;
    errs = 0;
    checks = 0;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_op = 3'd0;
    req_addr = '0;
    req_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 status after reset", {24'h0, status}, 32'h00);
    rd(8'h00, 16'hFFFF, "R1 word 0x00 erased");
    rd(8'hFF, 16'hFFFF, "R1 word 0xFF erased");

    // R4 program busy length, R2 AND result
    issue(3'd1, 8'h05, 16'hA5A5);
    count_busy(n);
    check("R4 program busy cycles", n, PROG_CYC);
    check("R4 done after program", {24'h0, status}, 32'h02);
    rd(8'h05, 16'hA5A5, "R2 programmed word");

    // R3 set-bit attempt
    issue(3'd1, 8'h05, 16'hFF00);
    wait_idle();
    check("R3 program error flag", {24'h0, status}, 32'h06);
    rd(8'h05, 16'hA500, "R2 AND of old and new");

    // R11 clear
    issue(3'd5, 8'h00, 16'h0);
    check("R11 flags cleared", {24'h0, status}, 32'h00);

    // preload bank 1 words
    issue(3'd1, 8'h93, 16'h0F0F);
    wait_idle();
    issue(3'd1, 8'h85, 16'h00FF);
    wait_idle();
    issue(3'd5, 8'h00, 16'h0);

    // erase block 9 in bank 1
    issue(3'd2, 8'h90, 16'h0);
    rd(8'h05, 16'hA500, "R5 idle bank read during erase");
    rd(8'h95, 16'h0041, "R6 busy bank read gives status");
    issue(3'd1, 8'h05, 16'h0000);
    check("R7 conflict flag", {24'h0, status}, 32'h61);
    issue(3'd3, 8'h00, 16'h0);
    check("R8 suspended status", {24'h0, status}, 32'h28);
    rd(8'h93, 16'h0F0F, "R8 suspended block old data");

    // R9 program during suspension
    issue(3'd1, 8'h21, 16'h1234);
    count_busy(n);
    check("R9 program while suspended busy cycles", n, PROG_CYC);
    rd(8'h21, 16'h1234, "R9 program other block while suspended");
    issue(3'd1, 8'h93, 16'h0000);
    check("R9 refused program flag", {24'h0, status}, 32'h3A);
    rd(8'h93, 16'h0F0F, "R9 suspended block unchanged");
    issue(3'd2, 8'h30, 16'h0);
    check("R7 erase while suspended rejected", {24'h0, status}, 32'h3A);

    // resume
    issue(3'd4, 8'h00, 16'h0);
    check("R8 resumed status", {24'h0, status}, 32'h73);
    count_busy(n);
    check("R4 remaining erase cycles after resume", n, ERS_CYC - 4);
    check("R8 status after erase", {24'h0, status}, 32'h32);
    rd(8'h93, 16'hFFFF, "R8 erased word 0x93");
    rd(8'h90, 16'hFFFF, "R10 erased first word");
    rd(8'h9F, 16'hFFFF, "R10 erased last word");
    rd(8'h85, 16'h00FF, "R10 neighbour block kept");
    rd(8'h05, 16'hA500, "R7 rejected program left word");

    // bank 0 busy, bank 1 readable
    issue(3'd5, 8'h00, 16'h0);
    issue(3'd1, 8'h10, 16'h00F0);
    rd(8'h93, 16'hFFFF, "R5 other bank read during program");
    rd(8'h11, 16'h0001, "R6 status from bank 0");
    wait_idle();
    rd(8'h10, 16'h00F0, "R2 bank 0 program");

    // R12 unused codes
    issue(3'd5, 8'h00, 16'h0);
    issue(3'd7, 8'h21, 16'h0000);
    issue(3'd6, 8'h21, 16'h0000);
    check("R12 status unchanged by unused codes", {24'h0, status}, 32'h00);
    rd(8'h21, 16'h1234, "R12 array unchanged by unused codes");

    repeat (4) @(negedge clk);
    check("R5 all reads answered", exp_q.size(), 0);
    finish_run();
  end
endmodule